// File: doc/BRIEF.md
# Attribute Palette Index Generator

This block sits between the display pixel fetch and the colour lookup DAC. Each incoming pixel becomes an 8-bit DAC index. In the planar display modes only the low four bits of a pixel matter. They are first masked by a plane-enable register. The masked nibble then selects one of sixteen 6-bit palette entries. The final index is assembled from that entry and from colour-select register bits. In the packed 8-bpp mode the palette is skipped and the pixel byte is passed through unchanged.

Pixels arrive on a valid/ready stream, and indices leave on a second valid/ready stream with one register stage between them. A pixel is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds its index unchanged and input is stalled, so no index is lost or replaced. The palette and the control registers share one register write port, and a write takes effect from the next clock edge.

Top module: `attr_palette_index`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. All sixteen palette entries are 0, the plane-enable mask is 4'hF, the colour-select register is 0, and the mode register is 0. In this state any pixel yields index 0.
- R2: In palette mode with the mid-select flag clear, the index is {csel[3:2], E[5:4], E[3:0]}. E is the palette entry addressed by the masked pixel nibble. Palette entry k is written at register address k (0..15), with data bits [5:0].
- R3: The pixel's bits [3:0] are ANDed with the plane-enable mask before the lookup. The mask sits in data bits [3:0] at register address 16.
- R4: With the mask set to 4'b0011, pixels that differ only in bits [3:2] give the same index. This is the four-colour mode.
- R5: When mode bit 0 is set (register address 18), the index equals the 8-bit pixel value. The mask and the palette have no effect.
- R6: In palette mode, index bits [7:6] equal colour-select bits [3:2]. Colour-select sits in data bits [3:0] at register address 17.
- R7: When mode bit 1 is set, index bits [5:4] equal colour-select bits [1:0] instead of palette bits [5:4]. Index bits [3:0] still come from the palette.
- R8: A register write takes effect on the next clock edge. A pixel accepted on the same edge as a write still uses the old value.
- R9: A pixel accepted on edge k appears with `out_valid` high after edge k, which is one cycle of latency. Indices leave in the order the pixels arrived.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_index` stays stable. During that time `in_ready` is low.
- R11: Writes to register addresses 19..31 change no state.
- R12: In palette mode, pixel bits [7:4] have no effect on the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address: 0..15 palette, 16 mask, 17 colour-select, 18 mode |
| reg_wdata | input | 6 | Register write data |
| in_valid | input | 1 | Pixel valid |
| in_ready | output | 1 | Pixel ready |
| in_pix | input | 8 | Pixel data |
| out_valid | output | 1 | Index valid |
| out_ready | input | 1 | Index ready |
| out_index | output | 8 | DAC index |

## Verification
The bench drives a long pixel stream while `out_ready` follows a pseudo-random pattern. A design that dropped or overwrote a stalled index, or let an index change while held, would break the scoreboard order or the hold check. The four-colour mask and the pixels with garbage upper nibbles expose a mask applied after the lookup, or a lookup that uses the full byte. A register write and a pixel on the same edge catch a palette read that bypasses the stored value. A write to an unmapped address, followed by pixels, would reveal a decoder that aliases onto the mask or the palette.

// File: rtl/api_pkg.sv
package api_pkg;
  parameter int PIX_W       = 8;
  parameter int PAL_ENTRIES = 16;
  parameter int PAL_W       = 6;
  parameter int IDX_W       = 8;
  parameter int REG_AW      = 5;

  localparam int PAL_AW  = $clog2(PAL_ENTRIES);
  localparam int CSEL_W  = 4;
  localparam int REG_DW  = PAL_W;
  localparam int LOW_W   = 4;

  localparam logic [REG_AW-1:0] ADDR_MASK = REG_AW'(PAL_ENTRIES);
  localparam logic [REG_AW-1:0] ADDR_CSEL = REG_AW'(PAL_ENTRIES + 1);
  localparam logic [REG_AW-1:0] ADDR_MODE = REG_AW'(PAL_ENTRIES + 2);

  typedef struct packed {
    logic              packed_mode;
    logic              mid_sel;
    logic [PAL_AW-1:0] plane_en;
    logic [CSEL_W-1:0] csel;
  } ctrl_t;
endpackage

// File: rtl/api_ctrl_regs.sv
module api_ctrl_regs
  import api_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [CSEL_W-1:0] wdata,
  output ctrl_t             ctrl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl.packed_mode <= 1'b0;
      ctrl.mid_sel     <= 1'b0;
      ctrl.plane_en    <= '1;
      ctrl.csel        <= '0;
    end else if (we) begin
      case (addr)
        ADDR_MASK: ctrl.plane_en <= wdata[PAL_AW-1:0];
        ADDR_CSEL: ctrl.csel     <= wdata;
        ADDR_MODE: begin
          ctrl.packed_mode <= wdata[0];
          ctrl.mid_sel     <= wdata[1];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/api_palette.sv
module api_palette
  import api_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PAL_AW-1:0] wr_addr,
  input  logic [PAL_W-1:0]  wr_data,
  input  logic [PAL_AW-1:0] rd_addr,
  output logic [PAL_W-1:0]  rd_data
);
  logic [PAL_ENTRIES-1:0][PAL_W-1:0] ent;

  for (genvar g = 0; g < PAL_ENTRIES; g++) begin : g_ent
    logic [PAL_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   q <= '0;
      else if (we && (wr_addr == PAL_AW'(g)))       q <= wr_data;
    end
    assign ent[g] = q;
  end

  assign rd_data = ent[rd_addr];
endmodule

// File: rtl/api_index_build.sv
module api_index_build
  import api_pkg::*;
(
  input  ctrl_t             ctrl,
  input  logic [PIX_W-1:0]  pix,
  output logic [PAL_AW-1:0] lookup_addr,
  input  logic [PAL_W-1:0]  pal_q,
  output logic [IDX_W-1:0]  index
);
  logic [1:0] hi_bits;
  logic [1:0] mid_bits;

  always_comb begin
    lookup_addr = pix[PAL_AW-1:0] & ctrl.plane_en;
    hi_bits     = ctrl.csel[3:2];
    mid_bits    = ctrl.mid_sel ? ctrl.csel[1:0] : pal_q[5:4];
    if (ctrl.packed_mode) index = pix;
    else                  index = {hi_bits, mid_bits, pal_q[LOW_W-1:0]};
  end
endmodule

// File: rtl/api_out_stage.sv
module api_out_stage
  import api_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IDX_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [IDX_W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R10
endmodule

// File: rtl/attr_palette_index.sv
module attr_palette_index
  import api_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PIX_W-1:0]  in_pix,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [IDX_W-1:0]  out_index
);
  ctrl_t             ctrl;
  logic [PAL_AW-1:0] lookup_addr;
  logic [PAL_W-1:0]  pal_q;
  logic [IDX_W-1:0]  next_index;
  logic              pal_we;

  assign pal_we = reg_we && (reg_addr[REG_AW-1:PAL_AW] == '0);

  api_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata[CSEL_W-1:0]), .ctrl(ctrl)
  );

  api_palette u_pal (
    .clk(clk), .rst_n(rst_n), .we(pal_we), .wr_addr(reg_addr[PAL_AW-1:0]),
    .wr_data(reg_wdata), .rd_addr(lookup_addr), .rd_data(pal_q)
  );

  api_index_build u_build (
    .ctrl(ctrl), .pix(in_pix), .lookup_addr(lookup_addr),
    .pal_q(pal_q), .index(next_index)
  );

  api_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(next_index), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_index)
  );

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R9
  AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && ctrl.packed_mode |=> out_index == $past(in_pix)); // R5
  AST_CSEL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !ctrl.packed_mode
      |=> out_index[7:6] == $past(ctrl.csel[3:2])); // R6
  AST_MID_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !ctrl.packed_mode && ctrl.mid_sel
      |=> out_index[5:4] == $past(ctrl.csel[1:0])); // R7
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R10
endmodule

// File: tb/attr_palette_index_tb.sv
`timescale 1ns/1ps
module attr_palette_index_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [5:0] reg_wdata = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_pix = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_index;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit rnd_ready = 1'b0;
  bit mon_on = 1'b0;

  logic [5:0] pal_m [16];
  logic [3:0] en_m = 4'hF;
  logic [3:0] csel_m = 4'h0;
  logic [1:0] mode_m = 2'b00;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #2.5 clk = ~clk;

  attr_palette_index u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .out_valid(out_valid), .out_ready(out_ready),
    .out_index(out_index)
  );

  function automatic logic [7:0] model(input logic [7:0] p);
    logic [3:0] a;
    logic [5:0] e;
    logic [1:0] mid;
    if (mode_m[0]) return p;
    a   = p[3:0] & en_m;
    e   = pal_m[a];
    mid = mode_m[1] ? csel_m[1:0] : e[5:4];
    return {csel_m[3:2], mid, e[3:0]};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_write(input logic [4:0] a, input logic [5:0] d);
    if (a < 5'd16)       pal_m[a[3:0]] = d;
    else if (a == 5'd16) en_m = d[3:0];
    else if (a == 5'd17) csel_m = d[3:0];
    else if (a == 5'd18) mode_m = d[1:0];
  endtask

  task automatic wr(input logic [4:0] a, input logic [5:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
    model_write(a, d);
  endtask

  task automatic send(input logic [7:0] p, input string tag);
    in_valid = 1'b1; in_pix = p;
    do @(negedge clk); while (!in_ready);
    exp_q.push_back(model(p)); tag_q.push_back(tag);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(posedge clk); #1;
  endtask

  // ready pattern
  initial begin
    logic [7:0] lfsr = 8'hA5;
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = rnd_ready ? lfsr[0] : 1'b1;
    end
  end

  // monitor / scoreboard
  initial begin
    bit         prev_stall = 1'b0;
    logic [7:0] prev_idx = '0;
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (prev_stall)
          check(out_valid && out_index == prev_idx, "R10 hold", out_index, prev_idx);
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R9 unexpected output", out_index, 0);
          end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(out_index == e, t, out_index, e);
          end
        end
        if (out_valid && !out_ready)
          check(!in_ready, "R10 in_ready low in stall", in_ready, 0);
        prev_stall = out_valid && !out_ready;
        prev_idx   = out_index;
      end
    end
  end

  // watchdog
  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) pal_m[i] = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
    mon_on = 1'b1;
    @(posedge clk); #1;
    send(8'h05, "R1 default index");
    send(8'hFF, "R1 default index");
    drain();

    // R9 latency
    in_valid = 1'b1; in_pix = 8'h03;
    @(negedge clk);
    check(in_ready, "R9 ready before accept", in_ready, 1);
    exp_q.push_back(model(8'h03)); tag_q.push_back("R9 latency value");
    @(posedge clk); #1; in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b1, "R9 valid one cycle after accept", out_valid, 1);
    @(negedge clk);
    check(out_valid == 1'b0, "R9 valid drops after drain", out_valid, 0);
    @(posedge clk); #1;

    for (int k = 0; k < 16; k++) wr(5'(k), 6'((k * 7 + 3) & 63));
    for (int k = 0; k < 16; k++) send(8'(k), "R2 palette lookup");
    drain();

    rnd_ready = 1'b1;
    for (int k = 0; k < 40; k++) send(8'((k * 37) & 255), "R9 R12 stream under backpressure");
    drain();

    wr(5'd16, 6'b000101);
    for (int k = 0; k < 16; k++) send(8'(k), "R3 plane mask");
    drain();

    wr(5'd16, 6'b000011);
    for (int k = 0; k < 16; k++) send(8'(k) | 8'hA0, "R4 four colour mask");
    drain();
    rnd_ready = 1'b0;
    wr(5'd16, 6'h0F);

    wr(5'd17, 6'b001011);
    for (int k = 0; k < 8; k++) send(8'(k * 2), "R6 colour select high");
    wr(5'd18, 6'b000010);
    for (int k = 0; k < 8; k++) send(8'(k * 2 + 1), "R7 mid select");
    drain();

    wr(5'd18, 6'b000001);
    wr(5'd16, 6'h0);
    for (int k = 0; k < 20; k++) send(8'((k * 53 + 11) & 255), "R5 packed bypass");
    drain();
    wr(5'd18, 6'b000000);
    wr(5'd16, 6'h0F);

    // R8 same-edge write and pixel
    reg_we = 1'b1; reg_addr = 5'd9; reg_wdata = 6'h2A;
    in_valid = 1'b1; in_pix = 8'h09;
    @(negedge clk);
    exp_q.push_back(model(8'h09)); tag_q.push_back("R8 old value on write edge");
    @(posedge clk); #1;
    reg_we = 1'b0; in_valid = 1'b0;
    model_write(5'd9, 6'h2A);
    send(8'h09, "R8 new value after write");
    drain();

    // R11 unmapped writes
    for (int a = 19; a < 32; a++) wr(5'(a), 6'h3F);
    for (int k = 0; k < 16; k++) send(8'(k), "R11 unmapped write no effect");
    drain();

    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule